// File: doc/BRIEF.md
# PCI Target Address-Phase Decoder

This block sits on the target side of a 32-bit multiplexed PCI bus and watches each address phase. When FRAME is first sampled low while the block is idle, it captures the address and command. The command is either single-cycle or, for a 64-bit address, spread across two consecutive phases. The block checks the address parity that arrives one clock later and sorts the command into memory, I/O, configuration or no space. It then decides whether to take the transaction. The data-phase logic uses the resulting flags to run the burst.

A positive claim is made for memory or I/O addresses that fall inside the configured windows, and for configuration commands that arrive with IDSEL high. This claim is raised one clock after the last address phase. When subtractive mode is strapped on, an unclaimed memory or I/O transaction can still be taken, but only on the fourth clock after FRAME was sampled, and only if no other agent claimed it first. For memory space, the low two address bits select the burst order. A reserved order sets a flag that tells the data path to disconnect once the first data phase completes.

Top module: `pci_addr_decoder`

## Requirements
- R1: After reset, and while no transaction is in progress, `claim`, `sub_claim`, `disc_first`, `prefetch` and `addr_perr` are low, and `space` and `burst` read 00.
- R2: `space` encodes the command as follows: 01 memory (commands 0110, 0111, 1100, 1110, 1111), 10 I/O (0010, 0011), 11 configuration (1010, 1011), and 00 for all other codes. A command with space 00 is never claimed.
- R3: For memory space, `burst` is 00 (linear) when address bits [1:0] are 00, 01 (cache-line wrap) when they are 10, and 10 (reserved) when they are 01 or 11. For every other space it is 00.
- R4: `disc_first` is high exactly when the space is memory and the burst order is reserved.
- R5: A memory address inside the memory window, or an I/O address inside the I/O window with a zero upper half, makes `claim` rise on the clock after the last address phase. Outside both windows there is no positive claim.
- R6: A configuration command is claimed only when IDSEL is high during the address phase that carries the command.
- R7: Command 1101 marks a dual-address cycle. The first phase carries address bits [31:0]. The second phase carries bits [63:32] and the real command. The decision comes one clock after the second phase, and a claimed transaction shows the full 64-bit address on `claim_addr`.
- R8: `prefetch` is high exactly when the command is 1100.
- R9: PAR arrives one clock after each address phase. The bits AD, C/BE and PAR of each phase must have even parity, and the low two address bits are included. If any phase fails this check, `addr_perr` pulses for one clock together with the decision, and no claim of either kind is made.
- R10: With `subtr_en` high, a memory or I/O transaction that misses its window and has good parity is claimed after the fourth clock following the FRAME sample, with `sub_claim` high. The claim is made only if `other_claim` was low at clocks one through four; if it was high at any of them, there is no claim.
- R11: A claim stays high until FRAME is sampled high, and drops on that clock. The flags are also cleared on that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | FRAME, active low |
| ad | input | 32 | Multiplexed address/data bus |
| cbe | input | 4 | Command / byte-enable bus |
| par | input | 1 | Parity for the previous clock's AD and C/BE |
| idsel | input | 1 | Configuration select for this agent |
| other_claim | input | 1 | High when another agent asserts DEVSEL |
| subtr_en | input | 1 | Strap that enables subtractive claiming |
| claim | output | 1 | This target claims the transaction (drives DEVSEL) |
| sub_claim | output | 1 | The claim is subtractive |
| space | output | 2 | Address space: 00 none, 01 memory, 10 I/O, 11 configuration |
| burst | output | 2 | Burst order: 00 linear, 01 wrap, 10 reserved |
| disc_first | output | 1 | Disconnect after the first data phase |
| prefetch | output | 1 | Read-multiple: prefetch the next 32-byte line |
| addr_perr | output | 1 | One-clock address parity error pulse |
| claim_addr | output | 64 | Captured address of the decided transaction |

## Verification
The assertions depend on the bus protocol around the block. FRAME stays low through the fourth clock after it is first sampled, and it stays low through the second phase of a dual-address cycle. At least one idle clock separates two transactions, and `other_claim` is only raised while a transaction is being decoded. The stimulus keeps to these rules by construction: every transaction holds FRAME low for five clocks, then idles for two, and pulses `other_claim` for one clock at most, at a chosen clock between one and four. The random mix varies command, window hit, low address bits, IDSEL, parity faults and the strap freely within those rules.

// File: rtl/pci_dec_pkg.sv
package pci_dec_pkg;

  localparam int AD_W  = 32;
  localparam int CBE_W = 4;
  localparam int LA_W  = 2 * AD_W;

  typedef enum logic [1:0] {
    SP_NONE = 2'd0,
    SP_MEM  = 2'd1,
    SP_IO   = 2'd2,
    SP_CFG  = 2'd3
  } space_e;

  typedef enum logic [1:0] {
    BO_LINEAR = 2'd0,
    BO_WRAP   = 2'd1,
    BO_RSVD   = 2'd2
  } border_e;

  localparam logic [CBE_W-1:0] CMD_DAC = 4'b1101;
  localparam logic [CBE_W-1:0] CMD_MRM = 4'b1100;

endpackage

// File: rtl/pci_cmd_class.sv
module pci_cmd_class
  import pci_dec_pkg::*;
(
  input  logic [CBE_W-1:0] cmd,
  output space_e           space,
  output logic             prefetch
);

  always_comb begin
    unique case (cmd)
      4'b0010, 4'b0011:                   space = SP_IO;
      4'b0110, 4'b0111, 4'b1100,
      4'b1110, 4'b1111:                   space = SP_MEM;
      4'b1010, 4'b1011:                   space = SP_CFG;
      default:                            space = SP_NONE;
    endcase
  end

  assign prefetch = (cmd == CMD_MRM);

endmodule

// File: rtl/pci_burst_order.sv
module pci_burst_order
  import pci_dec_pkg::*;
(
  input  space_e     space,
  input  logic [1:0] low_bits,
  output border_e    order,
  output logic       disc
);

  always_comb begin
    order = BO_LINEAR;
    disc  = 1'b0;
    if (space == SP_MEM) begin
      unique case (low_bits)
        2'b00:   order = BO_LINEAR;
        2'b10:   order = BO_WRAP;
        default: begin
          order = BO_RSVD;
          disc  = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/pci_win_match.sv
module pci_win_match #(
  parameter int               AW        = 32,
  parameter logic [AW-1:0]    BASE      = '0,
  parameter int               SIZE_LOG2 = 8
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);

  localparam logic [AW-1:0] OFFS_MASK = AW'((65'd1 << SIZE_LOG2) - 65'd1);
  localparam logic [AW-1:0] TAG_MASK  = ~OFFS_MASK;

  assign hit = (((addr ^ BASE) & TAG_MASK) == '0);

endmodule

// File: rtl/pci_addr_parity.sv
module pci_addr_parity #(
  parameter int W = 37
) (
  input  logic [W-1:0] bits,
  output logic         even_ok
);

  assign even_ok = ~(^bits);

endmodule

// File: rtl/pci_addr_decoder.sv
module pci_addr_decoder
  import pci_dec_pkg::*;
#(
  parameter logic [63:0] MEM_BASE      = 64'h0000_0000_8000_0000,
  parameter int          MEM_SIZE_LOG2 = 20,
  parameter logic [31:0] IO_BASE       = 32'h0000_1000,
  parameter int          IO_SIZE_LOG2  = 8,
  parameter int          SUB_DELAY     = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic [31:0] ad,
  input  logic [3:0]  cbe,
  input  logic        par,
  input  logic        idsel,
  input  logic        other_claim,
  input  logic        subtr_en,
  output logic        claim,
  output logic        sub_claim,
  output logic [1:0]  space,
  output logic [1:0]  burst,
  output logic        disc_first,
  output logic        prefetch,
  output logic        addr_perr,
  output logic [63:0] claim_addr
);

  localparam int CNT_W = $clog2(SUB_DELAY + 1) + 1;
  localparam int PAR_W = AD_W + CBE_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR2, ST_DECIDE, ST_SUBWAIT, ST_OWNED, ST_PASS
  } state_e;

  state_e             state_q, state_d;
  logic [AD_W-1:0]    lo_q, hi_q, ph_ad_q;
  logic [CBE_W-1:0]   ph_cbe_q, cmd_q;
  logic               idsel_q;
  logic               perr1_q, perr1_d;
  logic               seen_q, seen_d;
  logic [CNT_W-1:0]   cyc_q, cyc_d;

  space_e             space_q;
  border_e            burst_q;
  logic               disc_q, pref_q, perr_q, perr_d;
  logic               claim_q, sub_q;
  logic [LA_W-1:0]    addr_q;

  logic               ld_ph1, ld_ph2, ld_flags, clr_flags, claim_set, sub_set;

  space_e             dec_space;
  logic               dec_pref;
  border_e            dec_order;
  logic               dec_disc;
  logic               phase_ok;
  logic               mem_hit, io_hit, win_hit;
  logic               perr_now, sub_ok;

  pci_cmd_class u_class (
    .cmd      (cmd_q),
    .space    (dec_space),
    .prefetch (dec_pref)
  );

  pci_burst_order u_order (
    .space    (dec_space),
    .low_bits (lo_q[1:0]),
    .order    (dec_order),
    .disc     (dec_disc)
  );

  pci_addr_parity #(.W(PAR_W)) u_parity (
    .bits    ({ph_ad_q, ph_cbe_q, par}),
    .even_ok (phase_ok)
  );

  pci_win_match #(.AW(LA_W), .BASE(MEM_BASE), .SIZE_LOG2(MEM_SIZE_LOG2)) u_mem_win (
    .addr ({hi_q, lo_q}),
    .hit  (mem_hit)
  );

  pci_win_match #(.AW(AD_W), .BASE(IO_BASE), .SIZE_LOG2(IO_SIZE_LOG2)) u_io_win (
    .addr (lo_q),
    .hit  (io_hit)
  );

  always_comb begin
    unique case (dec_space)
      SP_MEM:  win_hit = mem_hit;
      SP_IO:   win_hit = io_hit && (hi_q == '0);
      SP_CFG:  win_hit = idsel_q;
      default: win_hit = 1'b0;
    endcase
  end

  assign perr_now = perr1_q | ~phase_ok;
  assign sub_ok   = subtr_en && !win_hit &&
                    ((dec_space == SP_MEM) || (dec_space == SP_IO));

  // next-state and control
  always_comb begin
    state_d   = state_q;
    ld_ph1    = 1'b0;
    ld_ph2    = 1'b0;
    ld_flags  = 1'b0;
    clr_flags = 1'b0;
    claim_set = 1'b0;
    sub_set   = 1'b0;
    perr_d    = 1'b0;
    perr1_d   = perr1_q;
    seen_d    = seen_q;
    cyc_d     = cyc_q;

    if (state_q != ST_IDLE && cyc_q != '1) begin
      cyc_d = cyc_q + 1'b1;
    end
    if (state_q == ST_ADDR2 || state_q == ST_DECIDE || state_q == ST_SUBWAIT) begin
      seen_d = seen_q | other_claim;
    end

    unique case (state_q)
      ST_IDLE: begin
        if (!frame_n) begin
          ld_ph1  = 1'b1;
          perr1_d = 1'b0;
          seen_d  = 1'b0;
          cyc_d   = CNT_W'(1);
          state_d = (cbe == CMD_DAC) ? ST_ADDR2 : ST_DECIDE;
        end
      end
      ST_ADDR2: begin
        ld_ph2  = 1'b1;
        perr1_d = ~phase_ok;
        state_d = ST_DECIDE;
      end
      ST_DECIDE: begin
        ld_flags = 1'b1;
        perr_d   = perr_now;
        if (perr_now) begin
          state_d = ST_PASS;
        end else if (win_hit) begin
          claim_set = 1'b1;
          state_d   = ST_OWNED;
        end else if (sub_ok) begin
          state_d = ST_SUBWAIT;
        end else begin
          state_d = ST_PASS;
        end
      end
      ST_SUBWAIT: begin
        if (seen_q || other_claim) begin
          state_d = ST_PASS;
        end else if (cyc_q == CNT_W'(SUB_DELAY)) begin
          claim_set = 1'b1;
          sub_set   = 1'b1;
          state_d   = ST_OWNED;
        end
      end
      ST_OWNED, ST_PASS: begin
        if (frame_n) begin
          clr_flags = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      perr1_q <= 1'b0;
      seen_q  <= 1'b0;
      cyc_q   <= '0;
      perr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      perr1_q <= perr1_d;
      seen_q  <= seen_d;
      cyc_q   <= cyc_d;
      perr_q  <= perr_d;
    end
  end

  // address-phase capture registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= '0;
      hi_q     <= '0;
      ph_ad_q  <= '0;
      ph_cbe_q <= '0;
      cmd_q    <= '0;
      idsel_q  <= 1'b0;
    end else if (ld_ph1) begin
      lo_q     <= ad;
      hi_q     <= '0;
      ph_ad_q  <= ad;
      ph_cbe_q <= cbe;
      cmd_q    <= cbe;
      idsel_q  <= idsel;
    end else if (ld_ph2) begin
      hi_q     <= ad;
      ph_ad_q  <= ad;
      ph_cbe_q <= cbe;
      cmd_q    <= cbe;
      idsel_q  <= idsel;
    end
  end

  // decision flag registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      space_q <= SP_NONE;
      burst_q <= BO_LINEAR;
      disc_q  <= 1'b0;
      pref_q  <= 1'b0;
      addr_q  <= '0;
    end else if (clr_flags) begin
      space_q <= SP_NONE;
      burst_q <= BO_LINEAR;
      disc_q  <= 1'b0;
      pref_q  <= 1'b0;
      addr_q  <= '0;
    end else if (ld_flags) begin
      space_q <= dec_space;
      burst_q <= dec_order;
      disc_q  <= dec_disc;
      pref_q  <= dec_pref;
      addr_q  <= {hi_q, lo_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claim_q <= 1'b0;
      sub_q   <= 1'b0;
    end else if (clr_flags) begin
      claim_q <= 1'b0;
      sub_q   <= 1'b0;
    end else begin
      if (claim_set) claim_q <= 1'b1;
      if (sub_set)   sub_q   <= 1'b1;
    end
  end

  assign claim      = claim_q;
  assign sub_claim  = sub_q;
  assign space      = space_q;
  assign burst      = burst_q;
  assign disc_first = disc_q;
  assign prefetch   = pref_q;
  assign addr_perr  = perr_q;
  assign claim_addr = addr_q;

  // checks on decisions
  assert_claim_space_R2: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> (space != SP_NONE));

  assert_disc_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
    disc_first |-> (space == SP_MEM && burst == BO_RSVD));

  assert_cfg_idsel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && space == SP_CFG) |-> idsel_q);

  assert_pref_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prefetch |-> (space == SP_MEM));

  assert_perr_noclaim_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_perr |-> !claim);

  assert_perr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_perr |=> !addr_perr);

  assert_sub_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sub_claim) |-> ($past(state_q) == ST_SUBWAIT && !$past(seen_q)));

  assert_claim_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && frame_n) |=> !claim);

endmodule

// File: tb/pci_addr_decoder_tb.sv
module pci_addr_decoder_tb;

  localparam logic [63:0] MB = 64'h0000_0000_8000_0000;
  localparam int          MS = 20;
  localparam logic [31:0] IB = 32'h0000_1000;
  localparam int          IS = 8;

  logic        clk;
  logic        rst_n;
  logic        frame_n;
  logic [31:0] ad;
  logic [3:0]  cbe;
  logic        par;
  logic        idsel;
  logic        other_claim;
  logic        subtr_en;
  logic        claim, sub_claim, disc_first, prefetch, addr_perr;
  logic [1:0]  space, burst;
  logic [63:0] claim_addr;

  int n_chk = 0;
  int n_err = 0;

  pci_addr_decoder #(
    .MEM_BASE(MB), .MEM_SIZE_LOG2(MS), .IO_BASE(IB), .IO_SIZE_LOG2(IS), .SUB_DELAY(4)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ad(ad), .cbe(cbe), .par(par),
    .idsel(idsel), .other_claim(other_claim), .subtr_en(subtr_en),
    .claim(claim), .sub_claim(sub_claim), .space(space), .burst(burst),
    .disc_first(disc_first), .prefetch(prefetch), .addr_perr(addr_perr),
    .claim_addr(claim_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  function automatic logic [1:0] f_space(input logic [3:0] c);
    case (c)
      4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: return 2'd1;
      4'b0010, 4'b0011:                             return 2'd2;
      4'b1010, 4'b1011:                             return 2'd3;
      default:                                      return 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] f_burst(input logic [1:0] sp, input logic [1:0] lo);
    if (sp != 2'd1) return 2'd0;
    if (lo == 2'b00) return 2'd0;
    if (lo == 2'b10) return 2'd1;
    return 2'd2;
  endfunction

  function automatic bit f_hit(input logic [1:0] sp, input logic [63:0] a, input bit ids);
    case (sp)
      2'd1: return (a >> MS) == (MB >> MS);
      2'd2: return (a[63:32] == 32'h0) && ((a[31:0] >> IS) == (IB >> IS));
      2'd3: return ids;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_tx(input bit dac, input logic [31:0] lo, input logic [31:0] hi,
                        input logic [3:0] cmd, input bit ids, input bit bad1,
                        input bit bad2, input int oc, input bit sen);
    logic [1:0]  e_sp, e_bo;
    logic [63:0] a64;
    logic [3:0]  c0;
    bit          e_disc, e_pref, e_perr, e_hit, e_pos, e_sub;
    int          ed;
    string       ctag;
    a64    = dac ? {hi, lo} : {32'h0, lo};
    c0     = dac ? 4'b1101 : cmd;
    e_sp   = f_space(cmd);
    e_bo   = f_burst(e_sp, lo[1:0]);
    e_disc = (e_sp == 2'd1) && lo[0];
    e_pref = (cmd == 4'b1100);
    e_perr = bad1 || (dac && bad2);
    e_hit  = f_hit(e_sp, a64, ids);
    e_pos  = e_hit && !e_perr;
    e_sub  = sen && !e_perr && !e_hit && (e_sp == 2'd1 || e_sp == 2'd2) && (oc == 0);
    ed     = dac ? 2 : 1;
    ctag   = (e_sp == 2'd3) ? "R6" : "R5";

    @(negedge clk);
    frame_n = 1'b0; subtr_en = sen; other_claim = 1'b0;
    ad = lo; cbe = c0; idsel = ids; par = 1'($urandom);

    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k - 1 == ed) begin
        chk(dac ? "R7" : "R2", "space", space, e_sp);
        chk("R3", "burst", burst, e_bo);
        chk("R4", "disc_first", disc_first, e_disc);
        chk("R8", "prefetch", prefetch, e_pref);
        chk("R9", "addr_perr", addr_perr, e_perr);
        chk(ctag, "claim", claim, e_pos);
        if (e_pos) chk("R7", "claim_addr", claim_addr, a64);
      end
      if (k - 1 > ed && k - 1 <= 4) begin
        chk("R10", "claim", claim, e_pos || (e_sub && k - 1 == 4));
        if (k - 1 == ed + 1) chk("R9", "addr_perr", addr_perr, 1'b0);
      end
      if (k - 1 == 4) chk("R10", "sub_claim", sub_claim, e_sub);
      if (k - 1 == 5) begin
        chk("R11", "claim", claim, 1'b0);
        chk("R11", "space", space, 2'd0);
      end
      other_claim = (oc == k);
      if (k == 1) begin
        par = (^{lo, c0}) ^ bad1;
        if (dac) begin ad = hi; cbe = cmd; end
        else begin ad = $urandom; cbe = 4'($urandom); end
      end else if (k == 2 && dac) begin
        par = (^{hi, cmd}) ^ bad2;
        ad = $urandom; cbe = 4'($urandom);
      end else begin
        ad = $urandom; cbe = 4'($urandom); par = 1'($urandom);
      end
      if (k >= 5) frame_n = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R11 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    int seed;
    bit dac, ids, b1, b2, sen;
    logic [31:0] lo, hi;
    logic [3:0] cmd;
    int oc;
    seed = $urandom(32'd1234);
    rst_n = 1'b0; frame_n = 1'b1; ad = '0; cbe = '0; par = 1'b0;
    idsel = 1'b0; other_claim = 1'b0; subtr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "claim", claim, 1'b0);
    chk("R1", "sub_claim", sub_claim, 1'b0);
    chk("R1", "space", space, 2'd0);
    chk("R1", "burst", burst, 2'd0);
    chk("R1", "disc_first", disc_first, 1'b0);
    chk("R1", "prefetch", prefetch, 1'b0);
    chk("R1", "addr_perr", addr_perr, 1'b0);

    // directed corner cases
    run_tx(0, 32'h8000_0100, 0, 4'b0110, 0, 0, 0, 0, 0); // R3 linear hit
    run_tx(0, 32'h8000_0102, 0, 4'b0111, 0, 0, 0, 0, 0); // R3 wrap
    run_tx(0, 32'h8000_0101, 0, 4'b1110, 0, 0, 0, 0, 0); // R4 reserved 01
    run_tx(0, 32'h8000_0103, 0, 4'b1111, 0, 0, 0, 0, 0); // R4 reserved 11
    run_tx(0, 32'h8000_0200, 0, 4'b1100, 0, 0, 0, 0, 0); // R8 prefetch
    run_tx(0, 32'h0000_1010, 0, 4'b0010, 0, 0, 0, 0, 0); // R5 io hit
    run_tx(0, 32'h0000_2010, 0, 4'b0011, 0, 0, 0, 0, 0); // R5 io miss
    run_tx(0, 32'h0000_0040, 0, 4'b1010, 1, 0, 0, 0, 0); // R6 cfg with idsel
    run_tx(0, 32'h0000_0040, 0, 4'b1011, 0, 0, 0, 0, 1); // R6 cfg no idsel
    run_tx(0, 32'h8000_0000, 0, 4'b0100, 0, 0, 0, 0, 1); // R2 reserved cmd
    run_tx(1, 32'h8000_0300, 32'h0, 4'b1100, 0, 0, 0, 0, 0); // R7 dac hit
    run_tx(1, 32'h8000_0300, 32'h1, 4'b0110, 0, 0, 0, 0, 1); // R7/R10 dac miss, sub
    run_tx(0, 32'h4000_0000, 0, 4'b0110, 0, 0, 0, 0, 1); // R10 subtractive
    run_tx(0, 32'h4000_0000, 0, 4'b0111, 0, 0, 0, 3, 1); // R10 blocked at 3
    run_tx(0, 32'h4000_0000, 0, 4'b0111, 0, 0, 0, 4, 1); // R10 blocked at 4
    run_tx(0, 32'h8000_0001, 0, 4'b0110, 0, 1, 0, 0, 1); // R9 low-bit parity
    run_tx(1, 32'h8000_0000, 32'h0, 4'b0110, 0, 1, 0, 0, 0); // R9 dac phase 1
    run_tx(1, 32'h8000_0000, 32'h0, 4'b0110, 0, 0, 1, 0, 1); // R9 dac phase 2

    // constrained random
    for (int i = 0; i < 400; i++) begin
      dac = ($urandom % 5) == 0;
      do cmd = 4'($urandom); while (cmd == 4'b1101);
      case ($urandom % 3)
        0: lo = MB[31:0] | ($urandom & 32'h000F_FFFF);
        1: lo = IB | ($urandom & 32'h0000_00FF);
        default: lo = $urandom;
      endcase
      hi  = ($urandom % 2) ? 32'h0 : $urandom;
      ids = 1'($urandom);
      b1  = ($urandom % 10) == 0;
      b2  = ($urandom % 10) == 0;
      sen = 1'($urandom);
      oc  = ($urandom % 3 == 0) ? int'(1 + $urandom % 4) : 0;
      run_tx(dac, lo, hi, cmd, ids, b1, b2, oc, sen);
    end

    summary();
    $finish;
  end

endmodule